// File: doc/BRIEF.md
# Pulse Arrival-Time Estimator

This block watches one channel of pedestal-corrected 10-bit samples, one sample per clock. It finds the leading edge of a pulse and reports when the pulse crossed a programmable threshold. The time has a coarse part and a 4-bit fractional part. The coarse part is a free-running sample counter. The fractional part comes from linear interpolation between the two samples that bracket the crossing. A fixed number of samples after the edge, the block captures the pulse amplitude. It then issues one result strobe that carries the timestamp and that amplitude.

A hit is accepted only when two consecutive samples lie above the threshold and the slope is still rising at the second of them. This rejects single-sample noise spikes and edges that are already turning over. The interpolation is set by a mode input. In one mode it is an exact restoring division, pipelined over one cycle per fraction bit. In the other it is a division-free estimate that divides by the power of two at or above the edge height. The synchronization input clears the coarse counter, so all channels that share that input keep aligned time.

Top module: `pulse_time_estimator`

## Requirements
- R1: While rst_n is low, and in the first cycle after it rises, hit_vld, hit_coarse, hit_frac and hit_peak are all zero.
- R2: A candidate edge needs three samples in a row: lo, then hi, then the current sample. lo must be at or below threshold, and both hi and the current sample must be strictly above it. A single sample above threshold between two samples at or below it yields no hit.
- R3: A candidate edge is dropped when the current sample is smaller than hi. The slope must not have turned negative at the second sample above threshold.
- R4: With mode_simple low when the hit qualifies, hit_frac equals floor(16*(threshold-lo)/(hi-lo)).
- R5: With mode_simple high when the hit qualifies, hit_frac equals floor(16*(threshold-lo)/2^p). Here p is the smallest integer with 2^p >= hi-lo.
- R6: hit_coarse is the counter value tagged to the lo sample. A sample presented in the cycle right after a cycle with sync_clr high is tagged 0. Each later cycle adds 1, and the count wraps modulo 2^16.
- R7: hit_peak is the sample presented 12 cycles after hi. hit_vld is high for exactly one cycle, starting at the clock edge that follows that sample.
- R8: While a hit is waiting for its peak sample, no new edge qualifies. Such an edge never produces a strobe of its own.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low reset |
| sync_clr | input | 1 | Clears the coarse counter |
| sample | input | 10 | Unsigned pedestal-corrected sample |
| threshold | input | 10 | Crossing threshold |
| mode_simple | input | 1 | 1: division-free fraction, 0: exact division |
| hit_vld | output | 1 | One-cycle result strobe |
| hit_coarse | output | 16 | Coarse time of the sample before the crossing |
| hit_frac | output | 4 | Fraction of a sample period past the coarse time |
| hit_peak | output | 10 | Amplitude captured at the fixed peak offset |

## Verification
A wrong sample history or wrong qualifying logic shows up as a missing, extra or shifted hit_vld strobe, 12 cycles after the faulty edge decision. A fault in the divider pipeline or in the mode latch shows only in hit_frac at that same strobe. A counter or tag fault shows in hit_coarse, and the wrap is exercised by letting the counter run past 2^16 after a sync. Because the reference model predicts every output on every cycle, a strobe that is missing or extra is caught in the cycle it should or should not appear.

// File: rtl/pte_pkg.sv
package pte_pkg;
    localparam int DATA_W   = 10;
    localparam int FRAC_W   = 4;
    localparam int CNT_W    = 16;
    localparam int PEAK_DLY = 12;

    typedef logic [DATA_W-1:0] smp_t;

    typedef struct packed {
        logic                vld;
        smp_t                rem;
        smp_t                den;
        logic [FRAC_W-1:0]   quo;
    } div_stg_t;
endpackage

// File: rtl/pte_edge_qual.sv
module pte_edge_qual
    import pte_pkg::*;
#(
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  smp_t          cur,
    input  smp_t          thr,
    input  logic [CW-1:0] ctr,
    output logic          cand,
    output smp_t          lo,
    output smp_t          hi,
    output logic [CW-1:0] lo_tag
);
    typedef struct packed {
        smp_t          s1;
        smp_t          s2;
        logic [CW-1:0] t1;
        logic [CW-1:0] t2;
    } hist_t;

    hist_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s2 = st_q.s1;
        st_d.t2 = st_q.t1;
        st_d.s1 = cur;
        st_d.t1 = ctr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // two above threshold in a row, previous at or below, slope still non-negative
    assign cand   = (cur > thr) && (st_q.s1 > thr) && (st_q.s2 <= thr) && (cur >= st_q.s1);
    assign lo     = st_q.s2;
    assign hi     = st_q.s1;
    assign lo_tag = st_q.t2;
endmodule

// File: rtl/pte_frac_div.sv
module pte_frac_div
    import pte_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  smp_t              num,
    input  smp_t              den,
    output logic              done,
    output logic [FRAC_W-1:0] quo
);
    div_stg_t stg_d [FRAC_W];
    div_stg_t stg_q [FRAC_W];

    always_comb begin
        for (int i = 0; i < FRAC_W; i++) begin
            div_stg_t          src;
            logic [DATA_W:0]   dbl;
            logic              bit_q;
            if (i == 0) begin
                src.vld = start;
                src.rem = num;
                src.den = den;
                src.quo = '0;
            end else begin
                src = stg_q[i-1];
            end
            dbl   = {src.rem, 1'b0};
            bit_q = (dbl >= {1'b0, src.den});
            stg_d[i].vld = src.vld;
            stg_d[i].den = src.den;
            stg_d[i].rem = bit_q ? DATA_W'(dbl - {1'b0, src.den}) : DATA_W'(dbl);
            stg_d[i].quo = {src.quo[FRAC_W-2:0], bit_q};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < FRAC_W; i++) stg_q[i] <= '0;
        end else begin
            for (int i = 0; i < FRAC_W; i++) stg_q[i] <= stg_d[i];
        end
    end

    assign done = stg_q[FRAC_W-1].vld;
    assign quo  = stg_q[FRAC_W-1].quo;

    AST_DIV_PROPER: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (num < den)); // R4
    AST_DIV_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(start, FRAC_W)); // R4
endmodule

// File: rtl/pulse_time_estimator.sv
module pulse_time_estimator
    import pte_pkg::*;
#(
    parameter int CW   = CNT_W,
    parameter int PDLY = PEAK_DLY
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync_clr,
    input  logic [DATA_W-1:0] sample,
    input  logic [DATA_W-1:0] threshold,
    input  logic              mode_simple,
    output logic              hit_vld,
    output logic [CW-1:0]     hit_coarse,
    output logic [FRAC_W-1:0] hit_frac,
    output logic [DATA_W-1:0] hit_peak
);
    localparam int WAIT_W = $clog2(PDLY + 1);
    localparam int SH_W   = $clog2(DATA_W + 1);

    typedef struct packed {
        logic [CW-1:0]     ctr;
        logic [WAIT_W-1:0] wait_cnt;
        logic [FRAC_W-1:0] frac;
        logic              frac_ok;
        logic              simple;
        logic [CW-1:0]     coarse;
        logic              o_vld;
        logic [CW-1:0]     o_coarse;
        logic [FRAC_W-1:0] o_frac;
        smp_t              o_peak;
    } state_t;

    state_t st_d, st_q;

    logic              cand, start, div_done;
    smp_t              lo, hi, num, den;
    logic [CW-1:0]     lo_tag;
    logic [FRAC_W-1:0] div_quo, simple_frac;

    pte_edge_qual #(.CW(CW)) i_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .cur    (sample),
        .thr    (threshold),
        .ctr    (st_q.ctr),
        .cand   (cand),
        .lo     (lo),
        .hi     (hi),
        .lo_tag (lo_tag)
    );

    assign num   = threshold - lo;
    assign den   = hi - lo;
    assign start = cand && (st_q.wait_cnt == '0);

    pte_frac_div i_div (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start && !mode_simple),
        .num   (num),
        .den   (den),
        .done  (div_done),
        .quo   (div_quo)
    );

    // division-free estimate: shift by the power of two at or above the edge height
    always_comb begin
        logic [SH_W-1:0]          p;
        logic [DATA_W+FRAC_W-1:0] scaled;
        p = '0;
        for (int i = DATA_W; i >= 0; i--) begin
            if (((DATA_W+1)'(1) << i) >= {1'b0, den}) p = SH_W'(i);
        end
        scaled      = {num, {FRAC_W{1'b0}}} >> p;
        simple_frac = scaled[FRAC_W-1:0];
    end

    always_comb begin
        st_d       = st_q;
        st_d.ctr   = sync_clr ? '0 : st_q.ctr + 1'b1;
        st_d.o_vld = 1'b0;
        if (div_done && !st_q.simple) begin
            st_d.frac    = div_quo;
            st_d.frac_ok = 1'b1;
        end
        if (st_q.wait_cnt != '0) begin
            st_d.wait_cnt = st_q.wait_cnt - 1'b1;
            if (st_q.wait_cnt == WAIT_W'(1)) begin
                st_d.o_vld    = 1'b1;
                st_d.o_coarse = st_q.coarse;
                st_d.o_frac   = st_q.frac;
                st_d.o_peak   = sample;
            end
        end
        if (start) begin
            st_d.wait_cnt = WAIT_W'(PDLY - 1);
            st_d.coarse   = lo_tag;
            st_d.simple   = mode_simple;
            st_d.frac_ok  = mode_simple;
            if (mode_simple) st_d.frac = simple_frac;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hit_vld    = st_q.o_vld;
    assign hit_coarse = st_q.o_coarse;
    assign hit_frac   = st_q.o_frac;
    assign hit_peak   = st_q.o_peak;

    AST_ONE_CYCLE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        hit_vld |=> !hit_vld); // R7
    AST_FRAC_BEFORE_PEAK: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.wait_cnt == WAIT_W'(1)) |-> st_q.frac_ok); // R4
    AST_NO_REARM_WHILE_WAITING: assert property (@(posedge clk) disable iff (!rst_n)
        (cand && st_q.wait_cnt != '0) |=> !(st_q.wait_cnt == WAIT_W'(PDLY - 1))); // R8
    AST_SYNC_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        sync_clr |=> (st_q.ctr == '0)); // R6
endmodule

// File: tb/test_pulse_time_estimator.sv
`timescale 1ns/1ps
module test_pulse_time_estimator;
    localparam int PDLY = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sync_clr = 1'b0;
    logic [9:0]  sample = '0;
    logic [9:0]  threshold = 10'd100;
    logic        mode_simple = 1'b0;
    logic        hit_vld;
    logic [15:0] hit_coarse;
    logic [3:0]  hit_frac;
    logic [9:0]  hit_peak;

    always #4 clk = ~clk;

    pulse_time_estimator i_pulse_time_estimator (
        .clk(clk), .rst_n(rst_n), .sync_clr(sync_clr), .sample(sample),
        .threshold(threshold), .mode_simple(mode_simple), .hit_vld(hit_vld),
        .hit_coarse(hit_coarse), .hit_frac(hit_frac), .hit_peak(hit_peak)
    );

    int n_cmp = 0, n_bad = 0, n_hits = 0;
    string phase = "R1";

    int m_ctr = 0, m_s1 = 0, m_s2 = 0, m_t1 = 0, m_t2 = 0, m_wait = 0;
    int m_pf = 0, m_pc = 0, m_pm = 0;
    int e_vld = 0, e_coarse = 0, e_frac = 0, e_peak = 0, e_mode = 0;

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s (%s): actual %0d expected %0d at %0t", tag, phase, act, exp, $time);
        end
    endtask

    // predicts register contents after the coming edge, from the inputs now applied
    task automatic model_edge(input int x, input int th, input int md, input int sy);
        int tag = m_ctr;
        int nv = 0;
        bit qual;
        if (m_wait == 1) begin
            nv = 1; e_coarse = m_pc; e_frac = m_pf; e_peak = x; e_mode = m_pm;
        end
        qual = (m_wait == 0) && (x > th) && (m_s1 > th) && (m_s2 <= th) && (x >= m_s1);
        if (m_wait > 0) m_wait--;
        if (qual) begin
            int num = th - m_s2;
            int den = m_s1 - m_s2;
            m_wait = PDLY - 1; m_pc = m_t2; m_pm = md;
            if (md != 0) begin
                int p = 0;
                while ((1 << p) < den) p++;
                m_pf = (num * 16) >> p;
            end else begin
                m_pf = (num * 16) / den;
            end
        end
        e_vld = nv;
        m_s2 = m_s1; m_t2 = m_t1; m_s1 = x; m_t1 = tag;
        m_ctr = (sy != 0) ? 0 : (m_ctr + 1) % 65536;
    endtask

    task automatic step(input int x, input bit sy);
        @(negedge clk);
        chk(phase, int'(hit_vld), e_vld);
        if (e_vld != 0) begin
            n_hits++;
            chk("R6", int'(hit_coarse), e_coarse);
            chk((e_mode != 0) ? "R5" : "R4", int'(hit_frac), e_frac);
            chk("R7", int'(hit_peak), e_peak);
        end
        sample = 10'(x);
        sync_clr = sy;
        model_edge(x, int'(threshold), int'(mode_simple), int'(sy));
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) step(0, 1'b0);
    endtask

    task automatic tri_pulse(input int slope, input int top);
        idle(3);
        for (int k = 0; k <= 2 * top; k++) begin
            int v = (k <= top) ? k * slope : (2 * top - k) * slope;
            step((v > 1023) ? 1023 : v, 1'b0);
        end
        idle(16);
    endtask

    task automatic set_cfg(input int th, input bit md);
        @(negedge clk);
        chk(phase, int'(hit_vld), e_vld);
        threshold = 10'(th);
        mode_simple = md;
        sample = '0;
        sync_clr = 1'b0;
        model_edge(0, th, int'(md), 0);
    endtask

    initial begin
        phase = "R1";
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R1", int'(hit_vld), 0);
            chk("R1", int'(hit_coarse), 0);
            chk("R1", int'(hit_frac), 0);
            chk("R1", int'(hit_peak), 0);
        end
        rst_n = 1'b1;
        model_edge(0, 100, 0, 0);
        step(0, 1'b0);
        chk("R1", int'(hit_peak), 0);

        phase = "R2";
        set_cfg(100, 1'b0);
        tri_pulse(37, 8);
        idle(3); step(500, 1'b0); step(0, 1'b0); idle(20);

        phase = "R3";
        idle(3); step(200, 1'b0); step(150, 1'b0); step(90, 1'b0); idle(20);

        phase = "R4";
        set_cfg(300, 1'b0);
        tri_pulse(53, 9);
        tri_pulse(111, 6);
        set_cfg(700, 1'b0);
        tri_pulse(97, 10);
        set_cfg(50, 1'b0);
        tri_pulse(17, 12);

        phase = "R5";
        set_cfg(300, 1'b1);
        tri_pulse(53, 9);
        tri_pulse(111, 6);
        set_cfg(50, 1'b1);
        tri_pulse(17, 12);

        phase = "R8";
        set_cfg(200, 1'b0);
        idle(3);
        step(250, 1'b0); step(400, 1'b0); step(100, 1'b0);
        step(300, 1'b0); step(450, 1'b0); step(600, 1'b0); step(100, 1'b0);
        idle(20);

        phase = "R6";
        step(0, 1'b1);
        idle(5);
        tri_pulse(70, 7);
        step(0, 1'b1);
        idle(65530);
        tri_pulse(45, 8);

        phase = "R7";
        set_cfg(120, 1'b0);
        tri_pulse(29, 14);

        idle(4);
        if (n_hits < 10) begin
            n_bad++;
            $display("FAIL R7: actual %0d strobes expected at least 10", n_hits);
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog (%s): actual timeout expected completion", phase);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule